// File: doc/BRIEF.md
# Serial Host Command and Status Port

This block is the slave end of a three-wire link to a host microcontroller. It has a data-in line, a shift clock and a load strobe. The host shifts bytes in most significant bit first and closes each byte with a load strobe. A write transaction is a command byte followed by a data byte. The data byte lands in one of six control registers: memory-system control, port direction, port drive level, attenuator/mute flags, attenuation level and options. The block drives those register contents as plain control fields toward the sequencing and audio logic, which sit outside it.

A read transaction is a single command byte. After its load strobe the block presents a status word on its serial output. The host clocks that word out with further shift clocks, and a final load strobe ends the read. Three status bytes come back as 8 bits each. One read returns a 16-bit buffer fill level. One of the status reads also clears the sticky event flags it reports.

The host link is asynchronous to the system clock. All three wires, and the general-purpose port pins, are brought into the system clock domain through flop synchronisers, and edges are detected there. A byte that is not exactly eight bits long when its load strobe arrives is thrown away.

Top module: `host_cmd_port`

## Requirements
- R1: A write is command byte 0x80..0x85, then a data byte, each shifted MSB first on rising shift-clock edges and closed by a rising load-strobe edge. The data byte is stored according to the command:
  - 0x80: all 8 bits to `mem_ctrl`.
  - 0x81: bits [N_PORTS-1:0] to `pin_oe`.
  - 0x83: bit7 to `att_enable`, bit6 to `mute_force`, bit5 to `mute_soft`, bit3 to `cmp_msb12`.
  - 0x84: all 8 bits to `att_level`.
  - 0x85: bit6 to `ext_ram`, bit5 to `jit_level_mode`, bit4 to `jit_edge_pol`.
- R2: Read command 0x92 returns 16 bits, MSB first: `fill_level[14:0]` followed by a constant 0 in the least significant bit.
- R3: In a 0x85 write, data bits [3:0] set `comp_mode`. The code is 0 for 4-bit (only bit0 set), 1 for 5-bit (only bit1), 2 for 6-bit (only bit2) and 3 for full-bit (only bit3). Any other pattern, including none set or several set, gives code 2.
- R4: A 0x82 write copies data bit i to `pin_drv[i]` only where `pin_oe[i]` is 1. Drive bits of ports configured as inputs keep their value.
- R5: Read command 0x93 returns one byte. Bit i (i < N_PORTS) is `pin_drv[i]` when `pin_oe[i]` is 1, and otherwise the synchronised `pin_in[i]`. The upper bits are 0.
- R6: After reset:
  - `att_level` is 64.
  - `comp_mode` is 2.
  - Every other control output, and `hs_sdo`, is 0.
- R7: Pulses on `ev_jitter`, `ev_overflow` and `ev_dec_halt` set sticky flags. Read 0x90 returns {jitter, overflow, 0, 0, `st_cmp_busy`, `st_enc_halt`, dec_halt, 0} (bit7 first) and clears the three sticky flags. An event in the clearing cycle survives.
- R8: A load strobe that follows a byte of other than exactly 8 bits changes no register and returns the port to waiting for a command. Command bytes that are not 0x80..0x85 or 0x90..0x93 are ignored.
- R9: A read word's first bit is on `hs_sdo` within 4 system clocks after the load-strobe rising edge. Each later rising shift-clock edge moves to the next bit within 4 clocks. `hs_sdo` holds between these edges and returns to 0 at the closing load strobe.
- R10: Read 0x91 returns {`st_empty`, `st_full`, `st_enc_run`, `st_dec_run`, 0, 0, 0, 0} (bit7 first).
- R11: Each completed 0x80 write gives exactly one single-cycle pulse on `mem_ctrl_stb`, with the new byte on `mem_ctrl` in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hs_sclk | input | 1 | Host shift clock |
| hs_sdi | input | 1 | Host serial data in |
| hs_load | input | 1 | Host load strobe, rising edge closes a byte |
| hs_sdo | output | 1 | Serial status out |
| ev_jitter | input | 1 | Jitter-margin event pulse |
| ev_overflow | input | 1 | Buffer overflow event pulse |
| ev_dec_halt | input | 1 | Decoder internal-stop event pulse |
| st_cmp_busy | input | 1 | Compare-connect running |
| st_enc_halt | input | 1 | Encoder stopped internally |
| st_empty | input | 1 | No valid data |
| st_full | input | 1 | Buffer full |
| st_enc_run | input | 1 | Encoder running |
| st_dec_run | input | 1 | Decoder running |
| fill_level | input | FILL_W | Valid-data fill level |
| pin_in | input | N_PORTS | Port pin input levels |
| pin_oe | output | N_PORTS | Port output enables |
| pin_drv | output | N_PORTS | Port drive levels |
| mem_ctrl | output | 8 | Memory-system control byte |
| mem_ctrl_stb | output | 1 | Pulse on each memory-control write |
| att_enable | output | 1 | Attenuator enable |
| mute_force | output | 1 | Forced mute |
| mute_soft | output | 1 | Soft mute |
| cmp_msb12 | output | 1 | Compare on 12 MSBs only |
| att_level | output | 8 | Attenuation level |
| ext_ram | output | 1 | External RAM in use |
| jit_level_mode | output | 1 | Jitter check by level rather than edge |
| jit_edge_pol | output | 1 | Jitter check edge or level polarity |
| comp_mode | output | 2 | Decoded compression mode |

## Verification
The bench uses the default parameters: N_PORTS = 4, FILL_W = 15, two synchroniser stages and a reset attenuation of 64. With four ports, every mix of directions and pin levels can be reached by random stimulus in a short run. The 15-bit fill level makes the all-ones boundary show the constant trailing zero. With two synchroniser stages, a shift-clock half period of six system clocks clears the edge-detect latency with margin. That margin makes every byte length from one to nine bits, including the discarded ones, reachable with exact cycle expectations.

// File: rtl/hcp_pkg.sv
package hcp_pkg;

  typedef enum logic [1:0] {
    CMP_4B   = 2'd0,
    CMP_5B   = 2'd1,
    CMP_6B   = 2'd2,
    CMP_FULL = 2'd3
  } cmp_mode_t;

  typedef enum logic [1:0] {
    HS_CMD  = 2'd0,
    HS_DATA = 2'd1,
    HS_READ = 2'd2
  } hs_state_t;

  localparam int BYTE_W = 8;
  localparam int NUM_WR = 6;

  // register slots addressed by the low opcode bits
  localparam logic [2:0] WI_MEM  = 3'd0;
  localparam logic [2:0] WI_DIR  = 3'd1;
  localparam logic [2:0] WI_DRV  = 3'd2;
  localparam logic [2:0] WI_ATTF = 3'd3;
  localparam logic [2:0] WI_LVL  = 3'd4;
  localparam logic [2:0] WI_OPT  = 3'd5;

  localparam logic [1:0] RI_EVT  = 2'd0;
  localparam logic [1:0] RI_RUN  = 2'd1;
  localparam logic [1:0] RI_FILL = 2'd2;
  localparam logic [1:0] RI_PINS = 2'd3;

  function automatic logic op_is_write(input logic [7:0] b);
    return (b[7:3] == 5'b10000) && (b[2:0] < 3'(NUM_WR));
  endfunction

  function automatic logic op_is_read(input logic [7:0] b);
    return b[7:2] == 6'b100100;
  endfunction

  // one-hot pick of the compression mode, everything else falls to 6-bit
  function automatic cmp_mode_t comp_decode(input logic [3:0] f);
    case (f)
      4'b0001: return CMP_4B;
      4'b0010: return CMP_5B;
      4'b0100: return CMP_6B;
      4'b1000: return CMP_FULL;
      default: return CMP_6B;
    endcase
  endfunction

endpackage

// File: rtl/hcp_sync.sv
module hcp_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[0] <= '0;
        else        chain[0] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[s] <= '0;
        else        chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hcp_rx.sv
module hcp_rx #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk_s,
  input  logic          sdi_s,
  input  logic          ld_s,
  output logic          shift_evt,
  output logic          load_evt,
  output logic [BW-1:0] rx_byte,
  output logic          rx_full
);
  localparam int CW = $clog2(BW + 2);
  localparam logic [CW-1:0] CNT_FULL = CW'(BW);

  logic          sclk_q, ld_q;
  logic [CW-1:0] cnt;

  assign shift_evt = sclk_s & ~sclk_q;
  assign load_evt  = ld_s & ~ld_q;
  assign rx_full   = (cnt == CNT_FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      ld_q    <= 1'b0;
      cnt     <= '0;
      rx_byte <= '0;
    end else begin
      sclk_q <= sclk_s;
      ld_q   <= ld_s;
      if (load_evt) begin
        cnt <= '0;
      end else if (shift_evt) begin
        rx_byte <= {rx_byte[BW-2:0], sdi_s};
        if (cnt <= CNT_FULL) cnt <= cnt + 1'b1;  // saturate one past full
      end
    end
  end
endmodule

// File: rtl/hcp_regs.sv
module hcp_regs
  import hcp_pkg::*;
#(
  parameter int          N_PORTS   = 4,
  parameter logic [7:0]  ATT_RESET = 8'd64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_evt,
  input  logic [2:0]         wr_idx,
  input  logic [7:0]         wr_data,
  output logic [7:0]         mem_ctrl,
  output logic               mem_ctrl_stb,
  output logic [N_PORTS-1:0] pin_oe,
  output logic [N_PORTS-1:0] pin_drv,
  output logic               att_enable,
  output logic               mute_force,
  output logic               mute_soft,
  output logic               cmp_msb12,
  output logic [7:0]         att_level,
  output logic               ext_ram,
  output logic               jit_level_mode,
  output logic               jit_edge_pol,
  output cmp_mode_t          comp_mode
);
  logic wr_drv;
  assign wr_drv = wr_evt && (wr_idx == WI_DRV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ctrl       <= '0;
      mem_ctrl_stb   <= 1'b0;
      pin_oe         <= '0;
      att_enable     <= 1'b0;
      mute_force     <= 1'b0;
      mute_soft      <= 1'b0;
      cmp_msb12      <= 1'b0;
      att_level      <= ATT_RESET;
      ext_ram        <= 1'b0;
      jit_level_mode <= 1'b0;
      jit_edge_pol   <= 1'b0;
      comp_mode      <= CMP_6B;
    end else begin
      mem_ctrl_stb <= wr_evt && (wr_idx == WI_MEM);
      if (wr_evt) begin
        case (wr_idx)
          WI_MEM:  mem_ctrl <= wr_data;
          WI_DIR:  pin_oe   <= wr_data[N_PORTS-1:0];
          WI_ATTF: begin
            att_enable <= wr_data[7];
            mute_force <= wr_data[6];
            mute_soft  <= wr_data[5];
            cmp_msb12  <= wr_data[3];
          end
          WI_LVL:  att_level <= wr_data;
          WI_OPT:  begin
            ext_ram        <= wr_data[6];
            jit_level_mode <= wr_data[5];
            jit_edge_pol   <= wr_data[4];
            comp_mode      <= comp_decode(wr_data[3:0]);
          end
          default: ;
        endcase
      end
    end
  end

  // drive levels update only on ports set as outputs
  for (genvar g = 0; g < N_PORTS; g++) begin : g_drv
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                    pin_drv[g] <= 1'b0;
      else if (wr_drv && pin_oe[g])  pin_drv[g] <= wr_data[g];
  end
endmodule

// File: rtl/hcp_stat.sv
module hcp_stat
  import hcp_pkg::*;
#(
  parameter int N_PORTS = 4,
  parameter int FILL_W  = 15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ev_jitter,
  input  logic               ev_overflow,
  input  logic               ev_dec_halt,
  input  logic               st_cmp_busy,
  input  logic               st_enc_halt,
  input  logic               st_empty,
  input  logic               st_full,
  input  logic               st_enc_run,
  input  logic               st_dec_run,
  input  logic [FILL_W-1:0]  fill_level,
  input  logic [N_PORTS-1:0] pin_s,
  input  logic [N_PORTS-1:0] pin_oe,
  input  logic [N_PORTS-1:0] pin_drv,
  input  logic               rd_evt,
  input  logic [1:0]         rd_idx,
  input  logic               shift_en,
  input  logic               tx_clr,
  output logic               sdo,
  output logic [FILL_W:0]    tx_word,
  output logic               flag_jit,
  output logic               flag_ovf,
  output logic               flag_dstop
);
  localparam int TX_W  = FILL_W + 1;
  localparam int PAD_W = TX_W - 8;

  logic       clr_evt;
  logic [7:0] echo_b, evt_b, run_b, sel_b;

  assign clr_evt = rd_evt && (rd_idx == RI_EVT);

  for (genvar i = 0; i < 8; i++) begin : g_echo
    if (i < N_PORTS) begin : g_port
      assign echo_b[i] = pin_oe[i] ? pin_drv[i] : pin_s[i];
    end else begin : g_pad
      assign echo_b[i] = 1'b0;
    end
  end

  assign evt_b = {flag_jit, flag_ovf, 2'b00, st_cmp_busy, st_enc_halt, flag_dstop, 1'b0};
  assign run_b = {st_empty, st_full, st_enc_run, st_dec_run, 4'b0000};

  always_comb begin
    case (rd_idx)
      RI_EVT:  sel_b = evt_b;
      RI_RUN:  sel_b = run_b;
      default: sel_b = echo_b;
    endcase
  end

  // sticky event flags: a new event wins over the read clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_jit   <= 1'b0;
      flag_ovf   <= 1'b0;
      flag_dstop <= 1'b0;
    end else begin
      flag_jit   <= ev_jitter   | (flag_jit   & ~clr_evt);
      flag_ovf   <= ev_overflow | (flag_ovf   & ~clr_evt);
      flag_dstop <= ev_dec_halt | (flag_dstop & ~clr_evt);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tx_word <= '0;
    else if (tx_clr)  tx_word <= '0;
    else if (rd_evt) begin
      if (rd_idx == RI_FILL) tx_word <= {fill_level, 1'b0};
      else                   tx_word <= {sel_b, {PAD_W{1'b0}}};
    end else if (shift_en) tx_word <= {tx_word[TX_W-2:0], 1'b0};
  end

  assign sdo = tx_word[TX_W-1];
endmodule

// File: rtl/host_cmd_port.sv
module host_cmd_port
  import hcp_pkg::*;
#(
  parameter int         N_PORTS     = 4,
  parameter int         FILL_W      = 15,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] ATT_RESET   = 8'd64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hs_sclk,
  input  logic               hs_sdi,
  input  logic               hs_load,
  output logic               hs_sdo,
  input  logic               ev_jitter,
  input  logic               ev_overflow,
  input  logic               ev_dec_halt,
  input  logic               st_cmp_busy,
  input  logic               st_enc_halt,
  input  logic               st_empty,
  input  logic               st_full,
  input  logic               st_enc_run,
  input  logic               st_dec_run,
  input  logic [FILL_W-1:0]  fill_level,
  input  logic [N_PORTS-1:0] pin_in,
  output logic [N_PORTS-1:0] pin_oe,
  output logic [N_PORTS-1:0] pin_drv,
  output logic [7:0]         mem_ctrl,
  output logic               mem_ctrl_stb,
  output logic               att_enable,
  output logic               mute_force,
  output logic               mute_soft,
  output logic               cmp_msb12,
  output logic [7:0]         att_level,
  output logic               ext_ram,
  output logic               jit_level_mode,
  output logic               jit_edge_pol,
  output logic [1:0]         comp_mode
);
  localparam int RV_W = 8 + 2 * N_PORTS + 4 + 8 + 3 + 2;

  logic [2:0]         link_s;
  logic [N_PORTS-1:0] pin_s;
  logic               shift_evt, load_evt, rx_full;
  logic [7:0]         rx_byte;
  hs_state_t          state;
  logic [7:0]         cmd_q;
  logic               wr_evt, rd_evt, shift_en, tx_clr;
  logic [2:0]         wr_idx;
  logic [1:0]         rd_idx;
  logic [FILL_W:0]    tx_word;
  logic               flag_jit, flag_ovf, flag_dstop;
  cmp_mode_t          comp_mode_e;
  logic [RV_W-1:0]    reg_view;

  hcp_sync #(.W(3), .STAGES(SYNC_STAGES)) u_link_sync (
    .clk(clk), .rst_n(rst_n), .d({hs_sclk, hs_sdi, hs_load}), .q(link_s));

  hcp_sync #(.W(N_PORTS), .STAGES(SYNC_STAGES)) u_pin_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_s));

  hcp_rx #(.BW(BYTE_W)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .sclk_s(link_s[2]), .sdi_s(link_s[1]), .ld_s(link_s[0]),
    .shift_evt(shift_evt), .load_evt(load_evt),
    .rx_byte(rx_byte), .rx_full(rx_full));

  // transaction events, named for the checker
  assign wr_evt   = load_evt && (state == HS_DATA) && rx_full;
  assign wr_idx   = cmd_q[2:0];
  assign rd_evt   = load_evt && (state == HS_CMD) && rx_full && op_is_read(rx_byte);
  assign rd_idx   = rx_byte[1:0];
  assign shift_en = shift_evt && (state == HS_READ);
  assign tx_clr   = load_evt && (state == HS_READ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= HS_CMD;
      cmd_q <= '0;
    end else if (load_evt) begin
      case (state)
        HS_CMD: begin
          if (rx_full && op_is_write(rx_byte)) begin
            state <= HS_DATA;
            cmd_q <= rx_byte;
          end else if (rd_evt) begin
            state <= HS_READ;
          end
        end
        default: state <= HS_CMD;
      endcase
    end
  end

  hcp_regs #(.N_PORTS(N_PORTS), .ATT_RESET(ATT_RESET)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_evt(wr_evt), .wr_idx(wr_idx), .wr_data(rx_byte),
    .mem_ctrl(mem_ctrl), .mem_ctrl_stb(mem_ctrl_stb),
    .pin_oe(pin_oe), .pin_drv(pin_drv),
    .att_enable(att_enable), .mute_force(mute_force),
    .mute_soft(mute_soft), .cmp_msb12(cmp_msb12),
    .att_level(att_level), .ext_ram(ext_ram),
    .jit_level_mode(jit_level_mode), .jit_edge_pol(jit_edge_pol),
    .comp_mode(comp_mode_e));

  assign comp_mode = comp_mode_e;

  hcp_stat #(.N_PORTS(N_PORTS), .FILL_W(FILL_W)) u_stat (
    .clk(clk), .rst_n(rst_n),
    .ev_jitter(ev_jitter), .ev_overflow(ev_overflow), .ev_dec_halt(ev_dec_halt),
    .st_cmp_busy(st_cmp_busy), .st_enc_halt(st_enc_halt),
    .st_empty(st_empty), .st_full(st_full),
    .st_enc_run(st_enc_run), .st_dec_run(st_dec_run),
    .fill_level(fill_level), .pin_s(pin_s),
    .pin_oe(pin_oe), .pin_drv(pin_drv),
    .rd_evt(rd_evt), .rd_idx(rd_idx),
    .shift_en(shift_en), .tx_clr(tx_clr),
    .sdo(hs_sdo), .tx_word(tx_word),
    .flag_jit(flag_jit), .flag_ovf(flag_ovf), .flag_dstop(flag_dstop));

  assign reg_view = {mem_ctrl, pin_oe, pin_drv, att_enable, mute_force, mute_soft,
                     cmp_msb12, att_level, ext_ram, jit_level_mode, jit_edge_pol,
                     comp_mode};
endmodule

// File: rtl/hcp_checker.sv
module hcp_checker #(
  parameter int         N_PORTS   = 4,
  parameter int         FILL_W    = 15,
  parameter logic [7:0] ATT_RESET = 8'd64,
  parameter int         RV_W      = 35
) (
  input logic               clk,
  input logic               rst_n,
  input logic               load_evt,
  input logic               shift_evt,
  input logic               rx_full,
  input logic               wr_evt,
  input logic [2:0]         wr_idx,
  input logic [7:0]         wr_data,
  input logic               rd_evt,
  input logic [1:0]         rd_idx,
  input logic               ev_jitter,
  input logic               ev_overflow,
  input logic               ev_dec_halt,
  input logic               flag_jit,
  input logic               flag_ovf,
  input logic               flag_dstop,
  input logic [FILL_W:0]    tx_word,
  input logic               hs_sdo,
  input logic [N_PORTS-1:0] pin_oe,
  input logic [N_PORTS-1:0] pin_drv,
  input logic [1:0]         comp_mode,
  input logic [7:0]         att_level,
  input logic [7:0]         mem_ctrl,
  input logic               mem_ctrl_stb,
  input logic [RV_W-1:0]    reg_view
);
  p_reset_state_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (att_level == ATT_RESET) && (mem_ctrl == 8'h00) && (comp_mode == 2'd2));

  p_drive_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && wr_idx == 3'd2) |=> (((pin_drv ^ $past(pin_drv)) & ~$past(pin_oe)) == '0));

  p_comp_default_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && wr_idx == 3'd5 && $countones(wr_data[3:0]) != 1) |=> (comp_mode == 2'd2));

  p_read_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_evt && rd_idx == 2'd0 && !ev_jitter && !ev_overflow && !ev_dec_halt)
      |=> (!flag_jit && !flag_ovf && !flag_dstop));

  p_event_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_jitter && ev_overflow && ev_dec_halt) |=> (flag_jit && flag_ovf && flag_dstop));

  p_partial_discard_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && !rx_full) |=> (reg_view == $past(reg_view)));

  p_fill_lsb_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_evt && rd_idx == 2'd2) |=> (tx_word[0] == 1'b0));

  p_sdo_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_evt && !shift_evt) |=> $stable(hs_sdo));

  p_stb_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ctrl_stb |=> !mem_ctrl_stb);

  p_stb_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && wr_idx == 3'd0) |=> (mem_ctrl_stb && mem_ctrl == $past(wr_data)));
endmodule

bind host_cmd_port hcp_checker #(
  .N_PORTS(N_PORTS), .FILL_W(FILL_W), .ATT_RESET(ATT_RESET), .RV_W(RV_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .load_evt(load_evt), .shift_evt(shift_evt),
  .rx_full(rx_full), .wr_evt(wr_evt), .wr_idx(wr_idx), .wr_data(rx_byte),
  .rd_evt(rd_evt), .rd_idx(rd_idx), .ev_jitter(ev_jitter),
  .ev_overflow(ev_overflow), .ev_dec_halt(ev_dec_halt),
  .flag_jit(flag_jit), .flag_ovf(flag_ovf), .flag_dstop(flag_dstop),
  .tx_word(tx_word), .hs_sdo(hs_sdo), .pin_oe(pin_oe), .pin_drv(pin_drv),
  .comp_mode(comp_mode), .att_level(att_level), .mem_ctrl(mem_ctrl),
  .mem_ctrl_stb(mem_ctrl_stb), .reg_view(reg_view)
);

// File: tb/sim_host_cmd_port.sv
`timescale 1ns/1ps
module sim_host_cmd_port;
  localparam int NP = 4;
  localparam int FW = 15;
  localparam int HP = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hs_sclk = 1'b0, hs_sdi = 1'b0, hs_load = 1'b0;
  logic hs_sdo;
  logic ev_jitter = 1'b0, ev_overflow = 1'b0, ev_dec_halt = 1'b0;
  logic st_cmp_busy = 1'b0, st_enc_halt = 1'b0, st_empty = 1'b0;
  logic st_full = 1'b0, st_enc_run = 1'b0, st_dec_run = 1'b0;
  logic [FW-1:0] fill_level = '0;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_oe, pin_drv;
  logic [7:0] mem_ctrl, att_level;
  logic mem_ctrl_stb, att_enable, mute_force, mute_soft, cmp_msb12;
  logic ext_ram, jit_level_mode, jit_edge_pol;
  logic [1:0] comp_mode;

  always #4 clk = ~clk;

  host_cmd_port u0 (
    .clk(clk), .rst_n(rst_n), .hs_sclk(hs_sclk), .hs_sdi(hs_sdi),
    .hs_load(hs_load), .hs_sdo(hs_sdo), .ev_jitter(ev_jitter),
    .ev_overflow(ev_overflow), .ev_dec_halt(ev_dec_halt),
    .st_cmp_busy(st_cmp_busy), .st_enc_halt(st_enc_halt),
    .st_empty(st_empty), .st_full(st_full), .st_enc_run(st_enc_run),
    .st_dec_run(st_dec_run), .fill_level(fill_level), .pin_in(pin_in),
    .pin_oe(pin_oe), .pin_drv(pin_drv), .mem_ctrl(mem_ctrl),
    .mem_ctrl_stb(mem_ctrl_stb), .att_enable(att_enable),
    .mute_force(mute_force), .mute_soft(mute_soft), .cmp_msb12(cmp_msb12),
    .att_level(att_level), .ext_ram(ext_ram), .jit_level_mode(jit_level_mode),
    .jit_edge_pol(jit_edge_pol), .comp_mode(comp_mode));

  int checks = 0, errors = 0, stb_seen = 0, stb_exp = 0;
  bit done = 1'b0;

  // bench model of the register file
  logic [7:0] m_mem = 8'h00, m_lvl = 8'd64;
  logic [NP-1:0] m_oe = '0, m_drv = '0;
  logic m_att = 0, m_fm = 0, m_sm = 0, m_c12 = 0, m_ext = 0, m_lm = 0, m_ep = 0;
  logic [1:0] m_comp = 2'd2;

  always @(posedge clk) if (rst_n && mem_ctrl_stb) stb_seen++;

  function automatic logic [1:0] exp_comp(input logic [3:0] f);
    if (f == 4'd1) return 2'd0;
    if (f == 4'd2) return 2'd1;
    if (f == 4'd8) return 2'd3;
    return 2'd2;
  endfunction

  function automatic logic [7:0] exp_echo(input logic [NP-1:0] oe, drv, pin);
    logic [7:0] r = 8'h00;
    for (int i = 0; i < NP; i++) r[i] = oe[i] ? drv[i] : pin[i];
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_regs(input string tag);
    chk({tag, " mem_ctrl"}, 32'(mem_ctrl), 32'(m_mem));
    chk({tag, " oe/drv"}, 32'({pin_oe, pin_drv}), 32'({m_oe, m_drv}));
    chk({tag, " attf"}, 32'({att_enable, mute_force, mute_soft, cmp_msb12}),
        32'({m_att, m_fm, m_sm, m_c12}));
    chk({tag, " level"}, 32'(att_level), 32'(m_lvl));
    chk({tag, " opt"}, 32'({ext_ram, jit_level_mode, jit_edge_pol, comp_mode}),
        32'({m_ext, m_lm, m_ep, m_comp}));
    chk({tag, " R11 strobes"}, 32'(stb_seen), 32'(stb_exp));
  endtask

  task automatic host_bits(input logic [15:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      hs_sdi = v[i];
      repeat (HP) @(negedge clk);
      hs_sclk = 1'b1;
      repeat (HP) @(negedge clk);
      hs_sclk = 1'b0;
    end
  endtask

  task automatic host_load();
    hs_load = 1'b1;
    repeat (HP) @(negedge clk);
    hs_load = 1'b0;
    repeat (HP) @(negedge clk);
  endtask

  task automatic model_write(input logic [2:0] idx, input logic [7:0] d);
    case (idx)
      3'd0: begin m_mem = d; stb_exp++; end
      3'd1: m_oe = d[NP-1:0];
      3'd2: m_drv = (m_drv & ~m_oe) | (d[NP-1:0] & m_oe);
      3'd3: begin m_att = d[7]; m_fm = d[6]; m_sm = d[5]; m_c12 = d[3]; end
      3'd4: m_lvl = d;
      default: begin m_ext = d[6]; m_lm = d[5]; m_ep = d[4]; m_comp = exp_comp(d[3:0]); end
    endcase
  endtask

  task automatic wr(input logic [2:0] idx, input logic [7:0] d);
    host_bits({8'h00, 5'b10000, idx}, 8);
    host_load();
    host_bits({8'h00, d}, 8);
    host_load();
    model_write(idx, d);
  endtask

  task automatic rd(input logic [7:0] op, input int n, output logic [15:0] r);
    host_bits({8'h00, op}, 8);
    host_load();
    r = '0;
    for (int i = 0; i < n; i++) begin
      r = {r[14:0], hs_sdo};
      hs_sclk = 1'b1;
      repeat (HP) @(negedge clk);
      hs_sclk = 1'b0;
      repeat (HP) @(negedge clk);
    end
    host_load();
  endtask

  task automatic pulse_events(input logic j, input logic o, input logic d);
    @(negedge clk);
    ev_jitter = j; ev_overflow = o; ev_dec_halt = d;
    @(negedge clk);
    ev_jitter = 0; ev_overflow = 0; ev_dec_halt = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    void'($urandom(32'd24680));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R6 reset state
    check_regs("R6 reset");
    chk("R6 sdo idle", 32'(hs_sdo), 32'd0);

    // R1 each write slot once
    wr(3'd0, 8'hA5); wr(3'd1, 8'h05); wr(3'd3, 8'hE8); wr(3'd4, 8'h9C); wr(3'd5, 8'h71);
    check_regs("R1 writes");

    // R3 compression decode corners
    wr(3'd5, 8'h00); chk("R3 none set", 32'(comp_mode), 32'd2);
    wr(3'd5, 8'h01); chk("R3 4-bit", 32'(comp_mode), 32'd0);
    wr(3'd5, 8'h02); chk("R3 5-bit", 32'(comp_mode), 32'd1);
    wr(3'd5, 8'h08); chk("R3 full", 32'(comp_mode), 32'd3);
    wr(3'd5, 8'h03); chk("R3 two set", 32'(comp_mode), 32'd2);
    wr(3'd5, 8'h0F); chk("R3 all set", 32'(comp_mode), 32'd2);

    // R4 drive gated by direction (ports 0,2 outputs)
    wr(3'd2, 8'h0F);
    chk("R4 gated drive", 32'(pin_drv), 32'(4'b0101));
    wr(3'd1, 8'h00); wr(3'd2, 8'h00);
    chk("R4 all inputs keep drive", 32'(pin_drv), 32'(4'b0101));

    // R5 port echo
    pin_in = 4'b1010;
    rd(8'h93, 8, r);
    chk("R5 echo inputs", 32'(r[7:0]), 32'(exp_echo(m_oe, m_drv, 4'b1010)));
    chk("R9 sdo back to 0", 32'(hs_sdo), 32'd0);

    // R2 fill word boundaries
    fill_level = 15'h7FFF; rd(8'h92, 16, r);
    chk("R2 fill all ones", 32'(r), 32'hFFFE);
    fill_level = 15'h0001; rd(8'h92, 16, r);
    chk("R2 fill one", 32'(r), 32'h0002);

    // R7 read to clear
    st_cmp_busy = 1; st_enc_halt = 0;
    pulse_events(1, 1, 1);
    rd(8'h90, 8, r);
    chk("R7 flags set", 32'(r[7:0]), 32'hCA);
    rd(8'h90, 8, r);
    chk("R7 flags cleared", 32'(r[7:0]), 32'h08);
    pulse_events(0, 1, 0);
    st_cmp_busy = 0; st_enc_halt = 1;
    rd(8'h90, 8, r);
    chk("R7 overflow only", 32'(r[7:0]), 32'h44);

    // R8 partial byte and unknown opcode
    host_bits(16'h0084, 8); host_load(); host_bits(16'h0011, 5); host_load();
    check_regs("R8 short data");
    host_bits(16'h0084, 8); host_load(); host_bits(16'h01FF, 9); host_load();
    check_regs("R8 long data");
    host_bits(16'h0086, 8); host_load(); host_bits(16'h00FF, 8); host_load();
    check_regs("R8 unknown op");
    host_bits(16'h0004, 3); host_load();
    wr(3'd4, 8'h33);
    check_regs("R8 recover after partial cmd");

    // random mix
    for (int it = 0; it < 70; it++) begin
      int k = int'($urandom % 10);
      if (k < 6) begin
        wr(3'(k), 8'($urandom));
        check_regs("R1 random write");
      end else if (k == 6) begin
        int n = int'($urandom % 8);
        if (n == 0) n = 9;
        host_bits(16'h0080 | 16'($urandom % 6), 8); host_load();
        host_bits(16'($urandom), n); host_load();
        check_regs("R8 random partial");
      end else if (k == 7) begin
        logic [NP-1:0] p = NP'($urandom);
        pin_in = p;
        rd(8'h93, 8, r);
        chk("R5 random echo", 32'(r[7:0]), 32'(exp_echo(m_oe, m_drv, p)));
      end else if (k == 8) begin
        logic [3:0] s = 4'($urandom);
        {st_empty, st_full, st_enc_run, st_dec_run} = s;
        rd(8'h91, 8, r);
        chk("R10 run status", 32'(r[7:0]), 32'({s, 4'b0000}));
      end else begin
        logic [FW-1:0] f = FW'($urandom);
        fill_level = f;
        rd(8'h92, 16, r);
        chk("R2 random fill", 32'(r), 32'({f, 1'b0}));
        chk("R9 sdo after read", 32'(hs_sdo), 32'd0);
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule